// File: doc/BRIEF.md
# In-Order Retirement Queue with Precise Faults

This block tracks every instruction in flight between dispatch and retirement. Each dispatched instruction receives a slot in a circular queue, in program order, along with its architectural destination and whether it is a store. Execution units report completion in any order by naming the slot. A report carries the result value and may carry a fault with a cause code. The queue never reorders anything. Only the oldest slot, the head, may leave.

When the head has completed cleanly, the block presents it on the retire outputs for exactly one cycle: slot index, destination and value, plus a store-commit strobe if the entry is a store. The register file and memory outside update from these outputs. When the head has completed with a fault, nothing retires. The block instead raises the exception outputs with the head's index and cause, and asserts flush in the same cycle. On the next edge every slot is discarded, including younger slots that already hold results, and the allocation point returns to the head. The next instruction dispatched therefore reuses the faulting slot's index.

Top module: `rob_core`

## Requirements
- R1: After reset the queue is empty. `disp_ready` is 1, and `ret_valid`, `store_commit`, `exc_valid` and `flush` are 0.
- R2: Each accepted dispatch (`disp_valid` and `disp_ready` both 1 at a clock edge) takes the slot shown on `disp_idx` in that cycle. Slot indices follow one another modulo DEPTH, starting from 0 after reset.
- R3: With DEPTH slots occupied, `disp_ready` is 0. A dispatch offered while the queue is full creates no entry, so no extra retirement ever appears for it.
- R4: Retirement happens only from the head, at most one entry per cycle, in allocation order. No entry retires while an older entry has not completed, whatever order the completions arrive in.
- R5: A retiring entry presents its slot on `ret_idx`, its dispatched destination on `ret_dest` and its reported value on `ret_value`. Retirement starts in the cycle after the head's completion report is accepted.
- R6: `store_commit` is 1 only in a cycle where `ret_valid` is 1 and the retiring entry was dispatched with `disp_is_store` = 1.
- R7: A head that completed with `cmp_fault` = 1 never retires. In that cycle `exc_valid` and `flush` are 1, `exc_idx` is the head slot, and `exc_cause` is the reported cause.
- R8: One cycle after a flush the queue is empty. Entries younger than the faulting one never retire, even ones that completed, including one whose completion arrives in the flush cycle itself. The next dispatch takes the faulting slot's index.
- R9: A dispatch accepted in a cycle where the head retires takes effect along with that retirement. Both entries are kept and handled correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_dest | input | ARCH_W | Architectural destination of dispatched instruction |
| disp_is_store | input | 1 | Dispatched instruction is a store |
| disp_ready | output | 1 | Queue can accept a dispatch this cycle |
| disp_idx | output | IDX_W | Slot assigned to a dispatch in this cycle |
| cmp_valid | input | 1 | Completion report valid |
| cmp_idx | input | IDX_W | Slot being completed |
| cmp_value | input | DATA_W | Result value |
| cmp_fault | input | 1 | The instruction faulted |
| cmp_cause | input | CAUSE_W | Fault cause code |
| ret_valid | output | 1 | Head retires this cycle |
| ret_idx | output | IDX_W | Slot of retiring entry |
| ret_dest | output | ARCH_W | Destination of retiring entry |
| ret_value | output | DATA_W | Value of retiring entry |
| store_commit | output | 1 | Retiring entry is a store; commit it to memory |
| exc_valid | output | 1 | Head has faulted |
| exc_idx | output | IDX_W | Slot of faulting entry |
| exc_cause | output | CAUSE_W | Cause of the fault |
| flush | output | 1 | Discard every in-flight entry at the next edge |

## Verification
Two pairs of events can land in the same cycle. The first is a dispatch and a retirement. The second is a completion report and a flush. The bench completes the head and then offers a new dispatch in the following cycle, where `ret_valid` is already high. It judges the pair by the new slot index and by both entries later retiring in order with their own data. It then faults a head whose younger entries have completed and sends a further completion exactly in the flush cycle. It expects a single exception, no retirement of any younger slot, and the next dispatch reusing the faulting slot.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    HS_EMPTY  = 2'd0,
    HS_WAIT   = 2'd1,
    HS_RETIRE = 2'd2,
    HS_FAULT  = 2'd3
  } head_state_e;

  function automatic head_state_e head_classify(input logic valid,
                                                input logic done,
                                                input logic fault);
    if (!valid)     return HS_EMPTY;
    else if (!done) return HS_WAIT;
    else if (fault) return HS_FAULT;
    else            return HS_RETIRE;
  endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             retire,
  input  logic             flush,
  output logic [PTR_W-1:0] head_ptr,
  output logic [PTR_W-1:0] tail_ptr,
  output logic [PTR_W-1:0] occupancy,
  output logic             full
);

  // DEPTH is a power of two, so the top bit acts as the lap marker.
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_distance(input logic [PTR_W-1:0] h,
                                                    input logic [PTR_W-1:0] t);
    return t - h;
  endfunction

  assign occupancy = ptr_distance(head_ptr, tail_ptr);
  assign full      = (occupancy == PTR_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else if (flush) begin
      tail_ptr <= head_ptr;
    end else begin
      if (retire) head_ptr <= ptr_step(head_ptr);
      if (alloc)  tail_ptr <= ptr_step(tail_ptr);
    end
  end

endmodule

// File: rtl/rob_slot.sv
module rob_slot #(
  parameter int ARCH_W  = 5,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               alloc_hit,
  input  logic [ARCH_W-1:0]  alloc_dest,
  input  logic               alloc_store,
  input  logic               cmp_hit,
  input  logic [DATA_W-1:0]  cmp_value,
  input  logic               cmp_fault,
  input  logic [CAUSE_W-1:0] cmp_cause,
  input  logic               retire_hit,
  output logic               valid,
  output logic               done,
  output logic               fault,
  output logic [ARCH_W-1:0]  dest,
  output logic [DATA_W-1:0]  value,
  output logic               store,
  output logic [CAUSE_W-1:0] cause
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      done  <= 1'b0;
      fault <= 1'b0;
    end else if (flush) begin
      valid <= 1'b0;
      done  <= 1'b0;
      fault <= 1'b0;
    end else if (alloc_hit) begin
      valid <= 1'b1;
      done  <= 1'b0;
      fault <= 1'b0;
    end else if (retire_hit) begin
      valid <= 1'b0;
      done  <= 1'b0;
    end else if (cmp_hit && valid) begin
      done  <= 1'b1;
      fault <= cmp_fault;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_hit) begin
      dest  <= alloc_dest;
      store <= alloc_store;
    end
    if (cmp_hit && valid) begin
      value <= cmp_value;
      cause <= cmp_cause;
    end
  end

endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
  parameter int DEPTH   = 8,
  parameter int ARCH_W  = 5,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 4,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               alloc,
  input  logic [IDX_W-1:0]   alloc_idx,
  input  logic [ARCH_W-1:0]  alloc_dest,
  input  logic               alloc_store,
  input  logic               cmp_valid,
  input  logic [IDX_W-1:0]   cmp_idx,
  input  logic [DATA_W-1:0]  cmp_value,
  input  logic               cmp_fault,
  input  logic [CAUSE_W-1:0] cmp_cause,
  input  logic               retire,
  input  logic [IDX_W-1:0]   head_idx,
  output logic               head_valid,
  output logic               head_done,
  output logic               head_fault,
  output logic [ARCH_W-1:0]  head_dest,
  output logic [DATA_W-1:0]  head_value,
  output logic               head_store,
  output logic [CAUSE_W-1:0] head_cause
);

  logic [DEPTH-1:0]   valid_v;
  logic [DEPTH-1:0]   done_v;
  logic [DEPTH-1:0]   fault_v;
  logic [DEPTH-1:0]   store_v;
  logic [ARCH_W-1:0]  dest_a  [DEPTH];
  logic [DATA_W-1:0]  value_a [DEPTH];
  logic [CAUSE_W-1:0] cause_a [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT_IDX = IDX_W'(g);
    logic alloc_hit, cmp_hit, retire_hit;
    assign alloc_hit  = alloc     && (alloc_idx == SLOT_IDX);
    assign cmp_hit    = cmp_valid && (cmp_idx   == SLOT_IDX);
    assign retire_hit = retire    && (head_idx  == SLOT_IDX);

    rob_slot #(
      .ARCH_W (ARCH_W),
      .DATA_W (DATA_W),
      .CAUSE_W(CAUSE_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .alloc_hit  (alloc_hit),
      .alloc_dest (alloc_dest),
      .alloc_store(alloc_store),
      .cmp_hit    (cmp_hit),
      .cmp_value  (cmp_value),
      .cmp_fault  (cmp_fault),
      .cmp_cause  (cmp_cause),
      .retire_hit (retire_hit),
      .valid      (valid_v[g]),
      .done       (done_v[g]),
      .fault      (fault_v[g]),
      .dest       (dest_a[g]),
      .value      (value_a[g]),
      .store      (store_v[g]),
      .cause      (cause_a[g])
    );
  end

  assign head_valid = valid_v[head_idx];
  assign head_done  = done_v[head_idx];
  assign head_fault = fault_v[head_idx];
  assign head_store = store_v[head_idx];
  assign head_dest  = dest_a[head_idx];
  assign head_value = value_a[head_idx];
  assign head_cause = cause_a[head_idx];

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel (
  input  logic                 head_valid,
  input  logic                 head_done,
  input  logic                 head_fault,
  input  logic                 head_store,
  output rob_pkg::head_state_e head_state,
  output logic                 ret_fire,
  output logic                 commit_fire,
  output logic                 fault_fire
);

  import rob_pkg::*;

  assign head_state  = head_classify(head_valid, head_done, head_fault);
  assign ret_fire    = (head_state == HS_RETIRE);
  assign fault_fire  = (head_state == HS_FAULT);
  assign commit_fire = ret_fire && head_store;

endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH   = 8,
  parameter int ARCH_W  = 5,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               disp_valid,
  input  logic [ARCH_W-1:0]  disp_dest,
  input  logic               disp_is_store,
  output logic               disp_ready,
  output logic [IDX_W-1:0]   disp_idx,
  input  logic               cmp_valid,
  input  logic [IDX_W-1:0]   cmp_idx,
  input  logic [DATA_W-1:0]  cmp_value,
  input  logic               cmp_fault,
  input  logic [CAUSE_W-1:0] cmp_cause,
  output logic               ret_valid,
  output logic [IDX_W-1:0]   ret_idx,
  output logic [ARCH_W-1:0]  ret_dest,
  output logic [DATA_W-1:0]  ret_value,
  output logic               store_commit,
  output logic               exc_valid,
  output logic [IDX_W-1:0]   exc_idx,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic               flush
);

  // Named internal events, visible to the bound checker.
  logic                 alloc_fire;
  logic                 retire_fire;
  logic                 fault_fire;
  logic                 commit_fire;
  logic                 full;
  logic [PTR_W-1:0]     head_ptr;
  logic [PTR_W-1:0]     tail_ptr;
  logic [PTR_W-1:0]     occupancy;
  logic [IDX_W-1:0]     head_idx;
  rob_pkg::head_state_e head_state;

  logic               head_valid, head_done, head_fault, head_store;
  logic [ARCH_W-1:0]  head_dest;
  logic [DATA_W-1:0]  head_value;
  logic [CAUSE_W-1:0] head_cause;

  assign head_idx   = head_ptr[IDX_W-1:0];
  assign disp_ready = !full && !fault_fire;
  assign alloc_fire = disp_valid && disp_ready;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc    (alloc_fire),
    .retire   (retire_fire),
    .flush    (fault_fire),
    .head_ptr (head_ptr),
    .tail_ptr (tail_ptr),
    .occupancy(occupancy),
    .full     (full)
  );

  rob_entry_store #(
    .DEPTH  (DEPTH),
    .ARCH_W (ARCH_W),
    .DATA_W (DATA_W),
    .CAUSE_W(CAUSE_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (fault_fire),
    .alloc      (alloc_fire),
    .alloc_idx  (tail_ptr[IDX_W-1:0]),
    .alloc_dest (disp_dest),
    .alloc_store(disp_is_store),
    .cmp_valid  (cmp_valid),
    .cmp_idx    (cmp_idx),
    .cmp_value  (cmp_value),
    .cmp_fault  (cmp_fault),
    .cmp_cause  (cmp_cause),
    .retire     (retire_fire),
    .head_idx   (head_idx),
    .head_valid (head_valid),
    .head_done  (head_done),
    .head_fault (head_fault),
    .head_dest  (head_dest),
    .head_value (head_value),
    .head_store (head_store),
    .head_cause (head_cause)
  );

  rob_retire_sel u_sel (
    .head_valid (head_valid),
    .head_done  (head_done),
    .head_fault (head_fault),
    .head_store (head_store),
    .head_state (head_state),
    .ret_fire   (retire_fire),
    .commit_fire(commit_fire),
    .fault_fire (fault_fire)
  );

  assign disp_idx     = tail_ptr[IDX_W-1:0];
  assign ret_valid    = retire_fire;
  assign ret_idx      = head_idx;
  assign ret_dest     = head_dest;
  assign ret_value    = head_value;
  assign store_commit = commit_fire;
  assign exc_valid    = fault_fire;
  assign exc_idx      = head_idx;
  assign exc_cause    = head_cause;
  assign flush        = fault_fire;

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_ready,
  input logic             ret_valid,
  input logic             store_commit,
  input logic             exc_valid,
  input logic             flush,
  input logic             full,
  input logic             alloc_fire,
  input logic             retire_fire,
  input logic [PTR_W-1:0] occupancy,
  input logic [PTR_W-1:0] head_ptr
);

  assert_alloc_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !retire_fire && !flush) |=> (occupancy == $past(occupancy) + 1'b1));

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !disp_ready);

  assert_head_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (head_ptr == $past(head_ptr) + 1'b1));

  assert_commit_on_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    store_commit |-> ret_valid);

  assert_fault_no_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !ret_valid);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occupancy == '0));

  assert_pair_keeps_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && retire_fire) |=> (occupancy == $past(occupancy)));

endmodule

bind rob_core rob_core_chk #(.PTR_W(PTR_W)) u_rob_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .disp_ready  (disp_ready),
  .ret_valid   (ret_valid),
  .store_commit(store_commit),
  .exc_valid   (exc_valid),
  .flush       (flush),
  .full        (full),
  .alloc_fire  (alloc_fire),
  .retire_fire (retire_fire),
  .occupancy   (occupancy),
  .head_ptr    (head_ptr)
);

// File: tb/tb_rob_core.sv
`timescale 1ns/1ps
module tb_rob_core;

  localparam int DEPTH = 8, ARCH_W = 5, DATA_W = 32, CAUSE_W = 4;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 1'b0, disp_is_store = 1'b0;
  logic [ARCH_W-1:0] disp_dest = '0;
  logic disp_ready;
  logic [IDX_W-1:0] disp_idx;
  logic cmp_valid = 1'b0, cmp_fault = 1'b0;
  logic [IDX_W-1:0] cmp_idx = '0;
  logic [DATA_W-1:0] cmp_value = '0;
  logic [CAUSE_W-1:0] cmp_cause = '0;
  logic ret_valid, store_commit, exc_valid, flush;
  logic [IDX_W-1:0] ret_idx, exc_idx;
  logic [ARCH_W-1:0] ret_dest;
  logic [DATA_W-1:0] ret_value;
  logic [CAUSE_W-1:0] exc_cause;

  always #2.5 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .ARCH_W(ARCH_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_dest(disp_dest), .disp_is_store(disp_is_store),
    .disp_ready(disp_ready), .disp_idx(disp_idx),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_value(cmp_value),
    .cmp_fault(cmp_fault), .cmp_cause(cmp_cause),
    .ret_valid(ret_valid), .ret_idx(ret_idx), .ret_dest(ret_dest), .ret_value(ret_value),
    .store_commit(store_commit), .exc_valid(exc_valid), .exc_idx(exc_idx),
    .exc_cause(exc_cause), .flush(flush)
  );

  int checks = 0, errors = 0, viol = 0;
  int rn = 0, en = 0;
  int r_idx [64], r_dest [64], r_val [64], r_st [64];
  int e_idx [8], e_cause [8];
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: samples outputs at the falling edge, away from input changes.
  always @(negedge clk) if (rst_n) begin
    if (store_commit && !ret_valid) viol++;
    if (ret_valid && exc_valid) viol++;
    if (ret_valid && rn < 64) begin
      r_idx[rn] = int'(ret_idx); r_dest[rn] = int'(ret_dest);
      r_val[rn] = int'(ret_value); r_st[rn] = int'(store_commit); rn++;
    end
    if (exc_valid && en < 8) begin
      e_idx[en] = int'(exc_idx); e_cause[en] = int'(exc_cause); en++;
    end
  end

  // All drive tasks start at posedge+1 and hold for exactly one cycle.
  task automatic dispatch(input int dest, input bit st, input int exp_idx, input string req);
    check({req, " disp_ready"}, int'(disp_ready), 1);
    check({req, " disp_idx"}, int'(disp_idx), exp_idx);
    disp_valid = 1'b1; disp_dest = ARCH_W'(dest); disp_is_store = st;
    @(posedge clk); #1;
    disp_valid = 1'b0;
  endtask

  task automatic complete(input int idx, input int val, input bit flt, input int cause);
    cmp_valid = 1'b1; cmp_idx = IDX_W'(idx); cmp_value = DATA_W'(val);
    cmp_fault = flt; cmp_cause = CAUSE_W'(cause);
    @(posedge clk); #1;
    cmp_valid = 1'b0; cmp_fault = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 disp_ready", int'(disp_ready), 1);
    check("R1 ret_valid", int'(ret_valid), 0);
    check("R1 exc_valid", int'(exc_valid), 0);
    check("R1 flush", int'(flush), 0);
    check("R1 store_commit", int'(store_commit), 0);
    @(posedge clk); #1;

    // R2: fill the queue, indices 0..DEPTH-1; odd slots are stores
    for (int i = 0; i < DEPTH; i++) dispatch(10 + i, bit'(i % 2), i, "R2");
    // R3: full queue refuses dispatch; offered one must leave no trace
    check("R3 full disp_ready", int'(disp_ready), 0);
    disp_valid = 1'b1; disp_dest = 5'd31; disp_is_store = 1'b1;
    @(posedge clk); #1;
    disp_valid = 1'b0;
    check("R3 still full", int'(disp_ready), 0);

    // R4: complete youngest first; nothing may retire until slot 0 is done
    for (int i = DEPTH - 1; i >= 1; i--) complete(i, 100 + i, 1'b0, 0);
    idle(2);
    check("R4 no retire before head done", rn, 0);
    complete(0, 100, 1'b0, 0);
    // R5: head retires in the cycle after its completion is accepted
    check("R5 retire starts", int'(ret_valid), 1);
    idle(DEPTH + 3);
    check("R3 retire count", rn, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      check("R4 order idx", r_idx[i], i);
      check("R5 dest", r_dest[i], 10 + i);
      check("R5 value", r_val[i], 100 + i);
      check("R6 store_commit", r_st[i], i % 2);
    end
    check("R3 ready after drain", int'(disp_ready), 1);

    // R9: dispatch in the same cycle the head retires
    dispatch(3, 1'b0, 0, "R2 wrap");
    complete(0, 55, 1'b0, 0);
    check("R9 head retiring now", int'(ret_valid), 1);
    dispatch(4, 1'b1, 1, "R9");
    complete(1, 66, 1'b0, 0);
    idle(3);
    check("R9 retire count", rn, DEPTH + 2);
    check("R9 first idx", r_idx[DEPTH], 0);
    check("R9 first value", r_val[DEPTH], 55);
    check("R9 second idx", r_idx[DEPTH + 1], 1);
    check("R9 second dest", r_dest[DEPTH + 1], 4);
    check("R9 second value", r_val[DEPTH + 1], 66);
    check("R6 second store", r_st[DEPTH + 1], 1);

    // R7/R8: fault at head slot 2 with younger slots already completed
    for (int i = 0; i < 4; i++) dispatch(20 + i, 1'b1, 2 + i, "R2 fault setup");
    complete(3, 33, 1'b0, 0);
    complete(4, 44, 1'b0, 0);
    complete(2, 22, 1'b1, 9);
    check("R7 exc_valid", int'(exc_valid), 1);
    check("R7 flush", int'(flush), 1);
    check("R7 exc_idx", int'(exc_idx), 2);
    check("R7 exc_cause", int'(exc_cause), 9);
    check("R7 no retire", int'(ret_valid), 0);
    check("R7 no commit", int'(store_commit), 0);
    complete(5, 55, 1'b0, 0);   // arrives in the flush cycle
    check("R8 exc cleared", int'(exc_valid), 0);
    check("R8 ready", int'(disp_ready), 1);
    idle(5);
    check("R8 no younger retire", rn, DEPTH + 2);
    check("R8 single exception", en, 1);
    dispatch(7, 1'b0, 2, "R8 reuse slot");
    complete(2, 77, 1'b0, 0);
    idle(3);
    check("R8 retire after flush", rn, DEPTH + 3);
    check("R8 idx", r_idx[DEPTH + 2], 2);
    check("R8 dest", r_dest[DEPTH + 2], 7);
    check("R8 value", r_val[DEPTH + 2], 77);
    check("R6 R7 cycle rules", viol, 0);

    finished = 1;
    summary();
  end

endmodule